// File: doc/BRIEF.md
# Push-Button Debounce and Report Status Generator

This block takes four active-low push buttons (volume up, volume down, playback mute, record mute) and turns them into the low nibble of the first byte of a 4-byte HID input report. The buttons are pulled up, so a pressed button reads low. Each raw pin is synchronised to the clock and debounced against a slow sample tick. Only a level that has held long enough is accepted.

Each report bit has one of two meanings. The two volume bits show the debounced button level for as long as the button is held. The two mute bits are sticky events. A mute bit is set only when a press has been followed by a release, and it stays set until the consumer of the report acknowledges it. The block also keeps a record-mute state that drives an indicator LED.

It flags that a report is waiting whenever the report byte changes. During bus suspend, a volume press raises a remote-wakeup request.

Top module: `btn_event_reporter`

## Requirements
- R1: A debounced button level changes only after the synchronised pin has differed from the accepted level on 16 consecutive sample ticks. Any cycle in which the pin matches the accepted level restarts that count.
- R2: Report bit 0 is 1 while the volume-up button (btn_n[0]) is held down after debouncing, and 0 once it has been released.
- R3: Report bit 1 follows the volume-down button (btn_n[1]) as a level in the same way.
- R4: Report bit 2 is set when the playback-mute button (btn_n[2]) is released after a press. A press alone leaves it at 0.
- R5: Report bit 3 is set when the record-mute button (btn_n[3]) is released after a press. A press alone leaves it at 0.
- R6: The record-mute LED is 0 after reset and toggles on each completed record-mute press-and-release.
- R7: While suspend is high, a debounced volume-up or volume-down press raises wake_req. wake_req stays high until suspend falls. Mute buttons, and presses made outside suspend, never raise it.
- R8: Report bits 7 to 4 always read 0. After reset the report byte, report_pending, the LED and wake_req are all 0.
- R9: report_pending goes high in the cycle the report byte changes. It is cleared by report_taken when no change happens in the same cycle.
- R10: report_taken clears both mute event bits (bits 3 and 2). It leaves the volume level bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | One-cycle debounce sample strobe |
| btn_n | input | 4 | Raw buttons, low = pressed: [0] vol up, [1] vol down, [2] play mute, [3] rec mute |
| suspend | input | 1 | Bus suspend state |
| report_taken | input | 1 | Strobe: report byte has been consumed |
| report_byte | output | 8 | Report byte 0 status bits |
| report_pending | output | 1 | Report content changed since last consume |
| rec_mute_led | output | 1 | High while recording is muted |
| wake_req | output | 1 | Remote-wakeup request |

## Verification
The hardest case to produce is a bounce that comes close to being accepted. The pin must hold its new level for nearly the full run of ticks, then briefly return to the old level, then hold the new level again. The stimulus gives ten ticks, restores the released level for several clock cycles with no tick, and then gives ten more ticks. The report must not change at that point, and it must change only after six further ticks. A second scenario holds the pin for exactly one tick short of the limit and checks that nothing is accepted. Wakeup is checked by mixing suspend with mute presses and with volume presses, and the request must hold until suspend drops.

// File: rtl/btn_pkg.sv
// Shared constants for the button reporter: button lane order and report
// byte bit positions. Assumes four buttons in a fixed lane order.
package btn_pkg;
    localparam int NUM_BTN      = 4;
    localparam int LANE_VOL_UP  = 0;
    localparam int LANE_VOL_DN  = 1;
    localparam int LANE_PMUTE   = 2;
    localparam int LANE_RMUTE   = 3;
    localparam int REPORT_W     = 8;
endpackage

// File: rtl/btn_debounce.sv
// One button lane: synchroniser chain followed by a tick-driven stability
// counter. Assumes an active-low pin with pull-up, so reset level is high.
// Emits one-cycle press/release pulses in the cycle the level is accepted.
module btn_debounce #(
    parameter int STABLE_TICKS = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_tick,
    input  logic pin_n,
    output logic pressed,
    output logic press_p,
    output logic release_p
);
    localparam int CW = $clog2(STABLE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_TICKS - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level_q;
    logic [CW-1:0]          cnt_q;
    logic                   sync_lvl;

    assign sync_lvl = sync_q[SYNC_STAGES-1];
    assign pressed  = ~level_q;

    // Bring the raw pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end

    // Count ticks on which the pin differs from the accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q   <= 1'b1;
            cnt_q     <= '0;
            press_p   <= 1'b0;
            release_p <= 1'b0;
        end else begin
            press_p   <= 1'b0;
            release_p <= 1'b0;
            if (sync_lvl == level_q) begin
                cnt_q <= '0;
            end else if (sample_tick) begin
                if (cnt_q == LAST) begin
                    level_q   <= sync_lvl;
                    cnt_q     <= '0;
                    press_p   <= ~sync_lvl;
                    release_p <= sync_lvl;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R1: the accepted level moves only on an edge where a tick was present.
    p_accept_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_q) |-> $past(sample_tick));

    // R1: the accepted level moves only while the synchronised pin disagrees.
    p_accept_needs_diff_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_q) |-> ($past(sync_lvl) != $past(level_q)));

    // R1: a press pulse coincides with a pressed level, never a released one.
    p_press_pulse_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        press_p |-> !level_q);
endmodule

// File: rtl/btn_report_core.sv
// Builds report byte 0 from debounced lanes, latches mute events, tracks
// the record-mute LED state, the pending flag and the wakeup request.
// Assumes press/release pulses are single-cycle and aligned with levels.
module btn_report_core
    import btn_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BTN-1:0]  pressed,
    input  logic [NUM_BTN-1:0]  press_p,
    input  logic [NUM_BTN-1:0]  release_p,
    input  logic                suspend,
    input  logic                report_taken,
    output logic [REPORT_W-1:0] report_byte,
    output logic                report_pending,
    output logic                rec_mute_led,
    output logic                wake_req
);
    logic [REPORT_W-1:0] report_q;
    logic [REPORT_W-1:0] report_d;
    logic                pm_evt_d;
    logic                rm_evt_d;
    logic                pend_q;
    logic                led_q;
    logic                wake_q;

    // Next mute event state: a release sets, a consume clears, set wins.
    always_comb begin
        pm_evt_d = release_p[LANE_PMUTE] | (report_q[LANE_PMUTE] & ~report_taken);
        rm_evt_d = release_p[LANE_RMUTE] | (report_q[LANE_RMUTE] & ~report_taken);
        report_d = '0;
        report_d[LANE_VOL_UP] = pressed[LANE_VOL_UP];
        report_d[LANE_VOL_DN] = pressed[LANE_VOL_DN];
        report_d[LANE_PMUTE]  = pm_evt_d;
        report_d[LANE_RMUTE]  = rm_evt_d;
    end

    // Register the report byte and the change-pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            report_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            report_q <= report_d;
            pend_q   <= (report_d != report_q) | (pend_q & ~report_taken);
        end
    end

    // Toggle the record-mute state on each completed press.
    always_ff @(posedge clk) begin
        if (!rst_n)                      led_q <= 1'b0;
        else if (release_p[LANE_RMUTE])  led_q <= ~led_q;
    end

    // Hold a wakeup request from a suspended volume press until resume.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= suspend &
                              (wake_q | press_p[LANE_VOL_UP] | press_p[LANE_VOL_DN]);
    end

    assign report_byte    = report_q;
    assign report_pending = pend_q;
    assign rec_mute_led   = led_q;
    assign wake_req       = wake_q;

    // R2: bit 0 follows the debounced volume-up level one cycle later.
    p_volup_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> report_q[LANE_VOL_UP] == $past(pressed[LANE_VOL_UP]));

    // R4: the playback-mute event bit rises only after a release pulse.
    p_pmute_after_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(report_q[LANE_PMUTE]) |-> $past(release_p[LANE_PMUTE]));

    // R6: the LED changes only after a record-mute release.
    p_led_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led_q) |-> $past(release_p[LANE_RMUTE]));

    // R7: a wakeup request can only rise while suspended.
    p_wake_in_suspend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_q) |-> $past(suspend));

    // R9: any report change is accompanied by a pending flag.
    p_pending_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(report_q) |-> pend_q);

    // R10: a consume never alters the volume level bits by itself.
    p_taken_keeps_vol_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (report_taken && $stable(pressed[LANE_VOL_UP])) |=>
            report_q[LANE_VOL_UP] == $past(report_q[LANE_VOL_UP]));
endmodule

// File: rtl/btn_event_reporter.sv
// Top: four debounce lanes feeding the report core. Assumes sample_tick
// is a single-cycle strobe and all button pins are active low.
module btn_event_reporter #(
    parameter int STABLE_TICKS = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_tick,
    input  logic [3:0] btn_n,
    input  logic       suspend,
    input  logic       report_taken,
    output logic [7:0] report_byte,
    output logic       report_pending,
    output logic       rec_mute_led,
    output logic       wake_req
);
    import btn_pkg::*;

    logic [NUM_BTN-1:0] pressed;
    logic [NUM_BTN-1:0] press_p;
    logic [NUM_BTN-1:0] release_p;

    // One identical debounce lane per button.
    for (genvar g = 0; g < NUM_BTN; g++) begin : g_lane
        btn_debounce #(
            .STABLE_TICKS (STABLE_TICKS),
            .SYNC_STAGES  (SYNC_STAGES)
        ) u_deb (
            .clk         (clk),
            .rst_n       (rst_n),
            .sample_tick (sample_tick),
            .pin_n       (btn_n[g]),
            .pressed     (pressed[g]),
            .press_p     (press_p[g]),
            .release_p   (release_p[g])
        );
    end

    btn_report_core u_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .pressed        (pressed),
        .press_p        (press_p),
        .release_p      (release_p),
        .suspend        (suspend),
        .report_taken   (report_taken),
        .report_byte    (report_byte),
        .report_pending (report_pending),
        .rec_mute_led   (rec_mute_led),
        .wake_req       (wake_req)
    );
endmodule

// File: tb/btn_event_reporter_tb.sv
`timescale 1ns/1ps
module btn_event_reporter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic [3:0] btn_n = 4'hF;
    logic       suspend = 1'b0;
    logic       report_taken = 1'b0;
    logic [7:0] report_byte;
    logic       report_pending;
    logic       rec_mute_led;
    logic       wake_req;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] b;
        logic       pend;
        logic       led;
        logic       wake;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    btn_event_reporter u_dut (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .btn_n(btn_n),
        .suspend(suspend), .report_taken(report_taken),
        .report_byte(report_byte), .report_pending(report_pending),
        .rec_mute_led(rec_mute_led), .wake_req(wake_req)
    );

    // Driver side: queue an expectation at a settled point.
    task automatic expect_now(input logic [7:0] b, input logic p,
                              input logic l, input logic w, input string tag);
        exp_t e;
        e.b = b; e.pend = p; e.led = l; e.wake = w; e.tag = tag;
        exp_q.push_back(e);
        #0.1;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sample_tick = 1'b1;
            @(negedge clk) sample_tick = 1'b0;
        end
        cycles(3);
    endtask

    task automatic set_pin(input int lane, input logic v);
        @(negedge clk) btn_n[lane] = v;
        cycles(4);
    endtask

    task automatic consume();
        @(negedge clk) report_taken = 1'b1;
        @(negedge clk) report_taken = 1'b0;
        cycles(2);
    endtask

    // Monitor: compare each queued expectation with the outputs.
    initial begin
        forever begin
            exp_t e;
            wait (exp_q.size() > 0);
            e = exp_q.pop_front();
            checks++;
            if (report_byte !== e.b || report_pending !== e.pend ||
                rec_mute_led !== e.led || wake_req !== e.wake) begin
                failures++;
                $display("FAIL %s: got byte=%h pend=%b led=%b wake=%b exp byte=%h pend=%b led=%b wake=%b",
                         e.tag, report_byte, report_pending, rec_mute_led, wake_req,
                         e.b, e.pend, e.led, e.wake);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got running exp finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cycles(4);
        rst_n = 1'b1;
        cycles(2);
        expect_now(8'h00, 0, 0, 0, "R8 reset state");

        // R1/R2: 15 ticks not enough, 16th accepts volume up.
        set_pin(0, 1'b0);
        ticks(15);
        expect_now(8'h00, 0, 0, 0, "R1 fifteen ticks rejected");
        ticks(1);
        expect_now(8'h01, 1, 0, 0, "R2 volume up level, R9 pending");
        consume();
        expect_now(8'h01, 0, 0, 0, "R10 consume keeps volume bit, R9 clears");
        set_pin(0, 1'b1);
        ticks(16);
        expect_now(8'h00, 1, 0, 0, "R2 volume up released");
        consume();

        // R1/R3: bounce restarts the run.
        set_pin(1, 1'b0);
        ticks(10);
        set_pin(1, 1'b1);
        set_pin(1, 1'b0);
        ticks(10);
        expect_now(8'h00, 0, 0, 0, "R1 bounce restarts count");
        ticks(6);
        expect_now(8'h02, 1, 0, 0, "R3 volume down level");
        set_pin(1, 1'b1);
        ticks(16);
        expect_now(8'h00, 1, 0, 0, "R3 volume down released");
        consume();

        // R4: playback mute needs press then release.
        set_pin(2, 1'b0);
        ticks(16);
        expect_now(8'h00, 0, 0, 0, "R4 press alone no event");
        set_pin(2, 1'b1);
        ticks(16);
        expect_now(8'h04, 1, 0, 0, "R4 play mute event after release");
        consume();
        expect_now(8'h00, 1, 0, 0, "R10 consume clears play mute event");
        consume();
        expect_now(8'h00, 0, 0, 0, "R9 second consume clears pending");

        // R5/R6: record mute event and LED toggle.
        set_pin(3, 1'b0);
        ticks(16);
        expect_now(8'h00, 0, 0, 0, "R5 record press alone no event");
        set_pin(3, 1'b1);
        ticks(16);
        expect_now(8'h08, 1, 1, 0, "R5 record event, R6 LED on");
        consume();
        consume();
        set_pin(3, 1'b0);
        ticks(16);
        set_pin(3, 1'b1);
        ticks(16);
        expect_now(8'h08, 1, 0, 0, "R6 LED toggles off");
        consume();
        consume();

        // R7: wakeup behaviour.
        set_pin(0, 1'b0);
        ticks(16);
        expect_now(8'h01, 1, 0, 0, "R7 no wake outside suspend");
        set_pin(0, 1'b1);
        ticks(16);
        consume();
        @(negedge clk) suspend = 1'b1;
        set_pin(2, 1'b0);
        ticks(16);
        set_pin(2, 1'b1);
        ticks(16);
        expect_now(8'h04, 1, 0, 0, "R7 mute press gives no wake");
        consume();
        consume();
        set_pin(1, 1'b0);
        ticks(16);
        expect_now(8'h02, 1, 0, 1, "R7 volume down wakes in suspend");
        set_pin(1, 1'b1);
        ticks(16);
        expect_now(8'h00, 1, 0, 1, "R7 wake held after release");
        @(negedge clk) suspend = 1'b0;
        cycles(2);
        expect_now(8'h00, 1, 0, 0, "R7 wake drops on resume, R8 reserved zero");

        cycles(4);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule